// File: doc/BRIEF.md
# Byte-Serial Packet Mailbox Port

This block lets a processor exchange whole network frames with a byte stream, using nothing but single-word register accesses. To send, software loads a byte count and then writes the frame one byte at a time into a transmit data port. Each accepted byte goes out on the transmit stream one cycle later, and the final byte carries a last marker. The transmit count drains to zero, and a transmit-done flag raises the interrupt line.

On the receive side, the block takes one frame from the input stream into a local byte memory. It then publishes the frame length in the receive count and flags receive-data-available. Software pulls the frame out by reading the receive data port repeatedly, and every read lowers the count by one. The input stream is held off until the frame has been drained and the flag acknowledged. A test bit lets software prove the interrupt path: setting it raises the line, it reads back as set exactly once, and the line stays high until software writes zero to interrupt control.

Top module: `pktmbox_port`

## Requirements
- R1: After reset, every count reads 0, interrupt control reads 0, `irq` is low, `rx_ready` is high and `tx_valid` is low.
- R2: Offset 0x00 returns the first four characters of the 8-character ID text, with the first character in bits 7:0. Offset 0x04 returns the last four characters in the same order. Offset 0x18 returns the routing parameter. Writes to these offsets change nothing.
- R3: After the transmit count (0x10) is loaded with N, each write to the transmit data port (0x20) drives that byte on `tx_data` with `tx_valid` high in the next cycle. The Nth byte also carries `tx_last`, and the count reads back the bytes still owed.
- R4: Only bits 7:0 of a transmit data write are forwarded. A data write while the transmit count is 0 produces no `tx_valid`.
- R5: After a frame is received, the receive count (0x0C) holds its length. Each read of 0x1C returns the next byte in arrival order in bits 7:0, with bits 31:8 zero, and lowers the count by one. A read at count 0 returns 0.
- R6: Completing a received frame sets interrupt-control bit 1 and raises `irq`. Writing 1 to bit 1 clears it, and writing 1 to bit 0 only leaves bit 1 set.
- R7: `rx_ready` is low while bit 1 is set or the receive count is nonzero. No byte is taken in that state.
- R8: A frame longer than `RX_DEPTH` bytes is discarded: the count stays 0, bit 1 stays clear and `irq` stays low. A frame of exactly `RX_DEPTH` bytes is kept.
- R9: Sending the last byte of a transmit frame sets interrupt-control bit 0 and raises `irq`. Writing 1 to bit 0 clears it.
- R10: Writing 1 to bit 31 raises `irq`. The next read of interrupt control shows bit 31 set and the read after shows it clear. `irq` stays high until interrupt control is written with 0.
- R11: The busy word (0x08) reads 1 while a transmit count is outstanding or a receive frame is partly taken, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the transmit frame |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the receive frame |
| rx_ready | output | 1 | Block can take a receive byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the edges of the receive buffer. A frame of exactly the buffer depth must survive, and one byte more must vanish. An off-by-one in the fill check would either lose a legal frame or raise a spurious interrupt with a truncated count. It also offers a second frame while the first is still pending. A block that ignored the acknowledge rule would overwrite unread data. On the transmit side it writes past the loaded count and expects silence on the stream. A design without that guard would emit stray bytes. The test-bit sequence is read twice and then cleared by a zero write. A design that cleared the line on read, or kept bit 31 sticky, fails there.

// File: rtl/pktmbox_pkg.sv
// Shared constants for the packet mailbox port: register offsets,
// interrupt-control bit positions and the frame-length counter width.
package pktmbox_pkg;
    // Counters must hold a frame length of up to 65536 bytes.
    localparam int LEN_W = 17;
    localparam int DW    = 32;

    localparam logic [5:0] OFF_ID_LO  = 6'h00;
    localparam logic [5:0] OFF_ID_HI  = 6'h04;
    localparam logic [5:0] OFF_BUSY   = 6'h08;
    localparam logic [5:0] OFF_RXCNT  = 6'h0C;
    localparam logic [5:0] OFF_TXCNT  = 6'h10;
    localparam logic [5:0] OFF_INTCTL = 6'h14;
    localparam logic [5:0] OFF_ROUTE  = 6'h18;
    localparam logic [5:0] OFF_RXDAT  = 6'h1C;
    localparam logic [5:0] OFF_TXDAT  = 6'h20;

    localparam int BIT_TXDONE = 0;
    localparam int BIT_RXDONE = 1;
    localparam int BIT_TEST   = 31;
endpackage

// File: rtl/pktmbox_tx.sv
// Transmit path: holds the outstanding byte count and forwards each
// data-port write as one registered stream byte.
// Assumes at most one data write per cycle and a sink that is always ready.
module pktmbox_tx
    import pktmbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic             dat_wr,
    input  logic [LEN_W-1:0] cnt_in,
    input  logic [7:0]       byte_in,
    output logic [LEN_W-1:0] cnt_o,
    output logic             done_o,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last
);
    logic [LEN_W-1:0] owed;
    logic             take;

    assign take   = dat_wr && (owed != '0);
    assign done_o = take && (owed == LEN_W'(1));
    assign cnt_o  = owed;

    // Load the frame length or count one byte off per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      owed <= '0;
        else if (cnt_wr) owed <= cnt_in;
        else if (take)   owed <= owed - LEN_W'(1);
    end

    // Register the outgoing stream byte and its last marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_last  <= 1'b0;
        end else begin
            tx_valid <= take;
            if (take) begin
                tx_data <= byte_in;
                tx_last <= (owed == LEN_W'(1));
            end
        end
    end

    assert_tx_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last) |-> (owed == '0 || $past(cnt_wr)));
    assert_tx_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && owed == '0) |=> !tx_valid);
endmodule

// File: rtl/pktmbox_rx.sv
// Receive path: fills a byte memory from the input stream, publishes the
// length when a fitting frame ends, and serves it back one byte per pop.
// Frames longer than DEPTH are discarded whole. Input is held off while a
// frame is pending (flag set) or still unread.
module pktmbox_rx
    import pktmbox_pkg::*;
#(
    parameter int DEPTH = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    output logic             rx_ready,
    input  logic             flag_i,
    input  logic             pop_i,
    output logic [LEN_W-1:0] cnt_o,
    output logic [7:0]       byte_o,
    output logic             inframe_o,
    output logic             done_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]       mem [DEPTH];
    logic [LEN_W-1:0] wcnt;
    logic [LEN_W-1:0] left;
    logic [PTR_W-1:0] rptr;
    logic             drop;
    logic             take;
    logic             full;

    assign rx_ready  = !flag_i && (left == '0);
    assign take      = rx_valid && rx_ready;
    assign full      = (wcnt >= LEN_W'(DEPTH));
    assign done_o    = take && rx_last && !drop && !full;
    assign cnt_o     = left;
    assign inframe_o = (wcnt != '0);
    assign byte_o    = (left != '0) ? mem[rptr] : 8'h00;

    // Store each byte that still fits in the buffer.
    always_ff @(posedge clk) begin
        if (take && !full) mem[wcnt[PTR_W-1:0]] <= rx_data;
    end

    // Track fill position and oversize state; publish or drain the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            drop <= 1'b0;
            left <= '0;
            rptr <= '0;
        end else begin
            if (take) begin
                if (rx_last) begin
                    wcnt <= '0;
                    drop <= 1'b0;
                end else begin
                    wcnt <= wcnt + LEN_W'(1);
                    if (full) drop <= 1'b1;
                end
            end
            if (done_o) begin
                left <= wcnt + LEN_W'(1);
                rptr <= '0;
            end else if (pop_i && left != '0) begin
                left <= left - LEN_W'(1);
                rptr <= rptr + PTR_W'(1);
            end
        end
    end

    assert_rx_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_i |-> !rx_ready);
    assert_rx_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && left != '0) |=> (left == $past(left) - LEN_W'(1)));
endmodule

// File: rtl/pktmbox_irq.sv
// Interrupt control: transmit-done and receive-available flags cleared by
// writing 1, plus a test request that reads back once and keeps the line
// up until a zero write. Set events win over same-cycle clears.
module pktmbox_irq
    import pktmbox_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic          ctl_rd,
    input  logic [DW-1:0] wdata,
    input  logic          tx_done_i,
    input  logic          rx_done_i,
    output logic [DW-1:0] ctl_o,
    output logic          rx_flag_o,
    output logic          irq_o
);
    logic tx_flag;
    logic rx_flag;
    logic test_seen;
    logic test_line;

    assign ctl_o     = {test_seen, {(DW-3){1'b0}}, rx_flag, tx_flag};
    assign rx_flag_o = rx_flag;
    assign irq_o     = tx_flag || rx_flag || test_line;

    // Update the two completion flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flag <= 1'b0;
            rx_flag <= 1'b0;
        end else begin
            if (tx_done_i)                          tx_flag <= 1'b1;
            else if (ctl_wr && wdata[BIT_TXDONE])   tx_flag <= 1'b0;
            if (rx_done_i)                          rx_flag <= 1'b1;
            else if (ctl_wr && wdata[BIT_RXDONE])   rx_flag <= 1'b0;
        end
    end

    // Track the test request's one-shot readback and its held line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_seen <= 1'b0;
            test_line <= 1'b0;
        end else if (ctl_wr) begin
            if (wdata[BIT_TEST]) begin
                test_seen <= 1'b1;
                test_line <= 1'b1;
            end else if (wdata == '0) begin
                test_line <= 1'b0;
            end
        end else if (ctl_rd) begin
            test_seen <= 1'b0;
        end
    end

    assert_rx_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_i |=> irq_o);
    assert_tx_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_i |=> irq_o);
    assert_test_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && !ctl_wr && ctl_o[BIT_TEST]) |=> !ctl_o[BIT_TEST]);
endmodule

// File: rtl/pktmbox_port.sv
// Packet mailbox port top: decodes the register bus into strobes for the
// transmit, receive and interrupt units and muxes read data.
// Assumes reg_wr and reg_rd are never high together.
module pktmbox_port
    import pktmbox_pkg::*;
#(
    parameter int          RX_DEPTH   = 1536,
    parameter logic [31:0] ROUTE_INFO = 32'd2,
    parameter logic [63:0] ID_TEXT    = "PKTMBOX1"
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [5:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    output logic          rx_ready,
    output logic          irq
);
    localparam logic [31:0] ID_LO = {ID_TEXT[39:32], ID_TEXT[47:40], ID_TEXT[55:48], ID_TEXT[63:56]};
    localparam logic [31:0] ID_HI = {ID_TEXT[7:0], ID_TEXT[15:8], ID_TEXT[23:16], ID_TEXT[31:24]};

    logic             txcnt_wr, txdat_wr, ctl_wr, ctl_rd, rxdat_rd;
    logic [LEN_W-1:0] tx_cnt, rx_cnt;
    logic             tx_done, rx_done, rx_flag, rx_inframe;
    logic [7:0]       rx_byte;
    logic [DW-1:0]    ctl_val;

    assign txcnt_wr = reg_wr && (reg_addr == OFF_TXCNT);
    assign txdat_wr = reg_wr && (reg_addr == OFF_TXDAT);
    assign ctl_wr   = reg_wr && (reg_addr == OFF_INTCTL);
    assign ctl_rd   = reg_rd && (reg_addr == OFF_INTCTL);
    assign rxdat_rd = reg_rd && (reg_addr == OFF_RXDAT);

    pktmbox_tx u_tx (
        .clk(clk), .rst_n(rst_n), .cnt_wr(txcnt_wr), .dat_wr(txdat_wr),
        .cnt_in(reg_wdata[LEN_W-1:0]), .byte_in(reg_wdata[7:0]),
        .cnt_o(tx_cnt), .done_o(tx_done),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );

    pktmbox_rx #(.DEPTH(RX_DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_ready(rx_ready), .flag_i(rx_flag),
        .pop_i(rxdat_rd), .cnt_o(rx_cnt), .byte_o(rx_byte),
        .inframe_o(rx_inframe), .done_o(rx_done)
    );

    pktmbox_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
        .wdata(reg_wdata), .tx_done_i(tx_done), .rx_done_i(rx_done),
        .ctl_o(ctl_val), .rx_flag_o(rx_flag), .irq_o(irq)
    );

    // Select read data by offset; unmapped offsets read as zero.
    always_comb begin
        unique case (reg_addr)
            OFF_ID_LO:  reg_rdata = ID_LO;
            OFF_ID_HI:  reg_rdata = ID_HI;
            OFF_BUSY:   reg_rdata = {31'b0, (tx_cnt != '0) || rx_inframe};
            OFF_RXCNT:  reg_rdata = {{(DW-LEN_W){1'b0}}, rx_cnt};
            OFF_TXCNT:  reg_rdata = {{(DW-LEN_W){1'b0}}, tx_cnt};
            OFF_INTCTL: reg_rdata = ctl_val;
            OFF_ROUTE:  reg_rdata = ROUTE_INFO;
            OFF_RXDAT:  reg_rdata = {24'b0, rx_byte};
            default:    reg_rdata = '0;
        endcase
    end

    assert_rxdat_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rxdat_rd |-> (reg_rdata[31:8] == 24'b0));
endmodule

// File: tb/pktmbox_port_test.sv
module pktmbox_port_test;
    localparam int          DEPTH = 16;
    localparam logic [63:0] IDS   = "PKTMBOX1";
    localparam logic [31:0] ROUTE = 32'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid, tx_last, rx_ready, irq;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    pktmbox_port #(.RX_DEPTH(DEPTH), .ROUTE_INFO(ROUTE), .ID_TEXT(IDS)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_ready(rx_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; #1;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1; d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0; #1;
    endtask

    task automatic push(input logic [7:0] d, input logic last);
        @(negedge clk); rx_valid = 1'b1; rx_data = d; rx_last = last; #1;
        while (!rx_ready) begin @(negedge clk); #1; end
        @(posedge clk);
    endtask

    task automatic push_end();
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0; #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 rx_ready", {31'b0, rx_ready}, 1);
        check("R1 tx_valid", {31'b0, tx_valid}, 0);
        rd(6'h0C, v); check("R1 rxcnt", v, 0);
        rd(6'h10, v); check("R1 txcnt", v, 0);
        rd(6'h14, v); check("R1 intctl", v, 0);
    endtask

    task automatic t_ident();
        logic [31:0] v;
        rd(6'h00, v); check("R2 id lo", v, {IDS[39:32], IDS[47:40], IDS[55:48], IDS[63:56]});
        rd(6'h04, v); check("R2 id hi", v, {IDS[7:0], IDS[15:8], IDS[23:16], IDS[31:24]});
        rd(6'h18, v); check("R2 route", v, ROUTE);
        wr(6'h00, 32'hFFFF_FFFF); wr(6'h18, 32'h0);
        rd(6'h00, v); check("R2 id after write", v, {IDS[39:32], IDS[47:40], IDS[55:48], IDS[63:56]});
        rd(6'h18, v); check("R2 route after write", v, ROUTE);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        wr(6'h10, 3);
        rd(6'h08, v); check("R11 busy tx", v, 1);
        for (int i = 0; i < 3; i++) begin
            wr(6'h20, 32'hDEAD_BE00 | (32'h40 + i));
            check("R3 tx_valid", {31'b0, tx_valid}, 1);
            check("R4 tx_data low byte", {24'b0, tx_data}, 32'h40 + i);
            check("R3 tx_last", {31'b0, tx_last}, (i == 2) ? 1 : 0);
            rd(6'h10, v); check("R3 txcnt", v, 2 - i);
        end
        rd(6'h08, v); check("R11 busy idle", v, 0);
        rd(6'h14, v); check("R9 txdone bit", v, 1);
        check("R9 irq", {31'b0, irq}, 1);
        wr(6'h20, 32'h77);
        check("R4 overrun no tx_valid", {31'b0, tx_valid}, 0);
        wr(6'h14, 1);
        rd(6'h14, v); check("R9 cleared", v, 0);
        check("R9 irq low", {31'b0, irq}, 0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        push(8'hA0, 1'b0);
        push_end();
        rd(6'h08, v); check("R11 busy rx mid", v, 1);
        for (int i = 1; i < 5; i++) push(8'hA0 + 8'(i), i == 4);
        push_end();
        rd(6'h0C, v); check("R5 rxcnt", v, 5);
        rd(6'h14, v); check("R6 rx bit", v, 2);
        check("R6 irq", {31'b0, irq}, 1);
        check("R7 blocked", {31'b0, rx_ready}, 0);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h55; rx_last = 1'b1;
        repeat (3) @(negedge clk);
        #1; check("R7 still blocked", {31'b0, rx_ready}, 0);
        rx_valid = 1'b0; rx_last = 1'b0;
        wr(6'h14, 1);
        rd(6'h14, v); check("R6 bit0 write keeps bit1", v, 2);
        for (int i = 0; i < 5; i++) begin
            rd(6'h1C, v); check("R5 rx byte", v, 32'hA0 + i);
            rd(6'h0C, v); check("R5 count down", v, 4 - i);
        end
        rd(6'h1C, v); check("R5 empty read", v, 0);
        check("R7 blocked by flag", {31'b0, rx_ready}, 0);
        wr(6'h14, 2);
        check("R6 irq cleared", {31'b0, irq}, 0);
        check("R7 ready again", {31'b0, rx_ready}, 1);
    endtask

    task automatic t_depth();
        logic [31:0] v;
        for (int i = 0; i < DEPTH; i++) push(8'(8'h10 + i), i == DEPTH - 1);
        push_end();
        rd(6'h0C, v); check("R8 exact depth kept", v, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            rd(6'h1C, v); check("R8 exact depth data", v, 32'h10 + i);
        end
        wr(6'h14, 2);
        for (int i = 0; i < DEPTH + 1; i++) push(8'(i), i == DEPTH);
        push_end();
        rd(6'h0C, v); check("R8 oversize count", v, 0);
        rd(6'h14, v); check("R8 oversize flag", v, 0);
        check("R8 oversize irq", {31'b0, irq}, 0);
        check("R8 ready", {31'b0, rx_ready}, 1);
    endtask

    task automatic t_test_irq();
        logic [31:0] v;
        wr(6'h14, 32'h8000_0000);
        check("R10 irq raised", {31'b0, irq}, 1);
        rd(6'h14, v); check("R10 first read", v, 32'h8000_0000);
        rd(6'h14, v); check("R10 second read", v, 0);
        check("R10 line held", {31'b0, irq}, 1);
        wr(6'h14, 0);
        check("R10 line cleared", {31'b0, irq}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_ident();
        t_tx();
        t_rx();
        t_depth();
        t_test_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule